// File: doc/BRIEF.md
# Windowed Capture and Frame Gate

This stage sits in a pixel stream that carries a data bus and three control strobes: pixel-valid, line-end and frame-end. It keeps only the pixels inside a programmable rectangle. Pixels outside the rectangle lose their valid strobe. Line-end and frame-end strobes pass through the window unchanged, so a later stage can still rebuild the image geometry. The output keeps the same stream format as the input.

On top of the window, a frame gate decides for each whole frame whether it is forwarded. In continuous mode every frame goes through. In count mode a loaded number N of frames goes through and then capture stops until software writes the control byte again. A dropped frame produces no valid, line-end or frame-end strobe at all. The stage only changes its gating decision on a frame boundary, so it never emits a partial frame.

Configuration uses a byte-wide write port. Each window bound is a 12-bit value, written as a low byte plus a high nibble. Every output is registered.

Top module: `roi_frame_gate`

## Requirements
- R1: A column counter counts valid pixels within a line and a row counter counts line-end strobes within a frame. Both are 0 for the first pixel of the first line after a frame-end, and the column counter is 0 again for the first pixel after each line-end.
- R2: A pixel lies inside the window when first_col <= column <= last_col and first_row <= row <= last_row. Both compares include their end points.
- R3: For a pixel inside the window in a forwarded frame, out_valid_o is asserted. For a pixel outside the window, out_valid_o stays low.
- R4: In a forwarded frame, out_eol_o and out_eof_o reproduce in_eol_i and in_eof_i whatever the window setting.
- R5: Config writes use cfg_addr_i as follows:
  - Addresses 0 to 7 hold the bounds in the order first_col, last_col, first_row, last_row. For each bound, the even address takes bits 7:0 and the odd address takes bits 11:8 from cfg_wdata_i[3:0].
  - Address 8 is frame control. cfg_wdata_i[4]=1 selects continuous mode and the count field is then ignored. Otherwise cfg_wdata_i[3:0] is the frame count N.
- R6: In count mode exactly N consecutive frames are forwarded after the control byte takes effect. Every later frame is dropped until the control byte is written again. N=0 forwards no frame.
- R7: In continuous mode every frame is forwarded.
- R8: A control write takes effect at the first in_eof_i strobe after the write cycle. The frame during which the write happens keeps the gating it started with.
- R9: For a dropped frame, out_valid_o, out_eol_o and out_eof_o all stay low for every cycle of that frame, including its frame-end.
- R10: All outputs appear exactly one clock after the corresponding input. out_data_o carries the in_data_i of that same input cycle.
- R11: After reset the outputs are low, the window spans the full 0..4095 range on both axes, and the gate is in count mode with N=0, so no frame is forwarded until the control byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | 4 | Config register address |
| cfg_wdata_i | input | 8 | Config write data |
| in_valid_i | input | 1 | Input pixel valid |
| in_eol_i | input | 1 | Input line-end strobe |
| in_eof_i | input | 1 | Input frame-end strobe |
| in_data_i | input | 32 | Input pixel data |
| out_valid_o | output | 1 | Output pixel valid, window and frame gated |
| out_eol_o | output | 1 | Output line-end strobe, frame gated |
| out_eof_o | output | 1 | Output frame-end strobe, frame gated |
| out_data_o | output | 32 | Output pixel data, one clock behind input |

## Verification
The embedded properties cover the rules that can be checked every cycle:
- no output strobe or data word appears without its source one clock earlier;
- the counters clear on line and frame ends;
- the forward decision changes only on a frame-end;
- count mode decrements once per forwarded frame;
- a continuous load always forwards.

Only the bench scenarios can show which exact pixels survive a given rectangle, including the corner, single-pixel and high-nibble cases. They also show the frame-by-frame sequence of forwarded and dropped frames across mode changes, mid-frame writes and exhausted counts.

// File: rtl/roi_pkg.sv
package roi_pkg;
  parameter int unsigned BOUND_W = 12;
  parameter int unsigned CFG_AW  = 4;
  parameter int unsigned CFG_DW  = 8;
  parameter int unsigned NUM_W   = 4;

  localparam int unsigned HI_W      = BOUND_W - 8;
  localparam int unsigned CTRL_ADDR = 8;
  localparam int unsigned CONT_BIT  = 4;

  typedef struct packed {
    logic [BOUND_W-1:0] col_first;
    logic [BOUND_W-1:0] col_last;
    logic [BOUND_W-1:0] row_first;
    logic [BOUND_W-1:0] row_last;
  } bounds_t;
endpackage

// File: rtl/roi_regs.sv
module roi_regs
  import roi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  input  logic              frame_end_i,
  output bounds_t           bounds_o,
  output logic              pend_o,
  output logic              pend_cont_o,
  output logic [NUM_W-1:0]  pend_num_o
);
  logic [3:0][BOUND_W-1:0] bnd_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[CFG_DW-1:CONT_BIT+1];

  for (genvar k = 0; k < 4; k++) begin : g_bound
    localparam logic [BOUND_W-1:0] RST_VAL = (k % 2 == 1) ? {BOUND_W{1'b1}} : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bnd_q[k] <= RST_VAL;
      end else if (we_i && addr_i == CFG_AW'(2*k)) begin
        bnd_q[k][7:0] <= wdata_i;
      end else if (we_i && addr_i == CFG_AW'(2*k+1)) begin
        bnd_q[k][BOUND_W-1:8] <= wdata_i[HI_W-1:0];
      end
    end
  end

  assign bounds_o.col_first = bnd_q[0];
  assign bounds_o.col_last  = bnd_q[1];
  assign bounds_o.row_first = bnd_q[2];
  assign bounds_o.row_last  = bnd_q[3];

  wire ctrl_wr = we_i && addr_i == CFG_AW'(CTRL_ADDR);

  // pending control byte, consumed at the next frame end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o      <= 1'b0;
      pend_cont_o <= 1'b0;
      pend_num_o  <= '0;
    end else if (ctrl_wr) begin
      pend_o      <= 1'b1;
      pend_cont_o <= wdata_i[CONT_BIT];
      pend_num_o  <= wdata_i[NUM_W-1:0];
    end else if (frame_end_i) begin
      pend_o      <= 1'b0;
    end
  end

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> pend_o); // R8
endmodule

// File: rtl/roi_counters.sv
module roi_counters
  import roi_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    valid_i,
  input  logic    eol_i,
  input  logic    eof_i,
  input  bounds_t bounds_i,
  output logic    in_win_o
);
  localparam logic [BOUND_W-1:0] CNT_MAX = {BOUND_W{1'b1}};

  logic [BOUND_W-1:0] col_q, row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (eof_i) begin
      col_q <= '0;
      row_q <= '0;
    end else if (eol_i) begin
      col_q <= '0;
      if (row_q != CNT_MAX) row_q <= row_q + 1'b1;
    end else if (valid_i && col_q != CNT_MAX) begin
      col_q <= col_q + 1'b1;
    end
  end

  // compare against the index of the pixel currently presented
  assign in_win_o = (col_q >= bounds_i.col_first) && (col_q <= bounds_i.col_last) &&
                    (row_q >= bounds_i.row_first) && (row_q <= bounds_i.row_last);

  AST_COL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eol_i || eof_i) |=> col_q == '0); // R1
  AST_ROW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_i |=> row_q == '0); // R1
endmodule

// File: rtl/frame_gate.sv
module frame_gate
  import roi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_end_i,
  input  logic             pend_i,
  input  logic             pend_cont_i,
  input  logic [NUM_W-1:0] pend_num_i,
  output logic             pass_o
);
  logic             cont_q;
  logic [NUM_W-1:0] left_q;
  logic             cont_n;
  logic [NUM_W-1:0] left_n;
  logic             pass_n;

  always_comb begin
    cont_n = pend_i ? pend_cont_i : cont_q;
    left_n = pend_i ? pend_num_i  : left_q;
    pass_n = cont_n || (left_n != '0);
  end

  // forwarding decision is taken once per frame, at the frame end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cont_q <= 1'b0;
      left_q <= '0;
      pass_o <= 1'b0;
    end else if (frame_end_i) begin
      cont_q <= cont_n;
      left_q <= (!cont_n && left_n != '0) ? left_n - 1'b1 : left_n;
      pass_o <= pass_n;
    end
  end

  AST_PASS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(pass_o)); // R8
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && !pend_i && !cont_q && left_q != '0) |=>
      (pass_o && left_q == $past(left_q) - 1'b1)); // R6
  AST_CONT_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && pend_i && pend_cont_i) |=> pass_o); // R7
endmodule

// File: rtl/roi_frame_gate.sv
module roi_frame_gate
  import roi_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic              in_valid_i,
  input  logic              in_eol_i,
  input  logic              in_eof_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic              out_eol_o,
  output logic              out_eof_o,
  output logic [DATA_W-1:0] out_data_o
);
  bounds_t          bounds;
  logic             pend, pend_cont;
  logic [NUM_W-1:0] pend_num;
  logic             in_win, pass;

  roi_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .frame_end_i(in_eof_i),
    .bounds_o   (bounds),
    .pend_o     (pend),
    .pend_cont_o(pend_cont),
    .pend_num_o (pend_num)
  );

  roi_counters u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .eol_i   (in_eol_i),
    .eof_i   (in_eof_i),
    .bounds_i(bounds),
    .in_win_o(in_win)
  );

  frame_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_end_i(in_eof_i),
    .pend_i     (pend),
    .pend_cont_i(pend_cont),
    .pend_num_i (pend_num),
    .pass_o     (pass)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_eol_o   <= 1'b0;
      out_eof_o   <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i && in_win && pass;
      out_eol_o   <= in_eol_i && pass;
      out_eof_o   <= in_eof_i && pass;
      out_data_o  <= in_data_i;
    end
  end

  AST_VALID_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i)); // R3
  AST_EOL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eol_o |-> $past(in_eol_i)); // R4
  AST_EOF_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eof_o |-> $past(in_eof_i)); // R4
  AST_DATA_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_data_o == $past(in_data_i)); // R10
endmodule

// File: tb/roi_frame_gate_tb_top.sv
`timescale 1ns/1ps
module roi_frame_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        vi = 1'b0, eli = 1'b0, efi = 1'b0;
  logic [31:0] di = '0;
  logic        vo, elo, efo;
  logic [31:0] dout;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R11";
  bit done = 1'b0;

  int          q_kind[$];
  logic [31:0] q_data[$];
  int          q_cyc[$];
  string       q_req[$];

  int c0 = 0, c1 = 4095, r0 = 0, r1 = 4095;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  roi_frame_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .in_valid_i(vi), .in_eol_i(eli), .in_eof_i(efi), .in_data_i(di),
    .out_valid_o(vo), .out_eol_o(elo), .out_eof_o(efo), .out_data_o(dout)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(int k, logic [31:0] d, string req);
    q_kind.push_back(k); q_data.push_back(d); q_cyc.push_back(cyc + 1); q_req.push_back(req);
  endtask

  // monitor: pops the scoreboard on every output strobe
  always @(negedge clk) begin
    if (rst_n) begin
      int k;
      k = vo ? 0 : (elo ? 1 : 2);
      if ((vo + elo + efo) > 1)
        check(0, cur_req, "several strobes at once", {vo, elo, efo}, 0);
      else if (vo || elo || efo) begin
        if (q_kind.size() == 0)
          check(0, cur_req, "unexpected output strobe", k, -1);
        else begin
          int ek, ec; logic [31:0] ed; string er;
          ek = q_kind.pop_front(); ed = q_data.pop_front();
          ec = q_cyc.pop_front();  er = q_req.pop_front();
          check(k == ek, er, "strobe kind", k, ek);
          check(cyc == ec, "R10", "output cycle", cyc, ec);
          if (ek == 0) check(dout == ed, er, "pixel data", dout, ed);
        end
      end
    end
  end

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    we = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic set_win(int a0, int a1, int b0, int b1);
    wr(0, a0 & 255); wr(1, a0 >> 8); wr(2, a1 & 255); wr(3, a1 >> 8);
    wr(4, b0 & 255); wr(5, b0 >> 8); wr(6, b1 & 255); wr(7, b1 >> 8);
    c0 = a0; c1 = a1; r0 = b0; r1 = b1;
  endtask

  // driver: drives one frame and pushes the outputs it expects
  task automatic frame(int fid, int w, int h, bit fwd, string req);
    cur_req = req;
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        @(posedge clk); #1;
        vi = 1'b1; di = {fid[7:0], y[11:0], x[11:0]};
        if (fwd && x >= c0 && x <= c1 && y >= r0 && y <= r1) push(0, di, req);
      end
      @(posedge clk); #1;
      vi = 1'b0;
      if (y < h - 1) begin eli = 1'b1; if (fwd) push(1, 0, req); end
      else begin efi = 1'b1; if (fwd) push(2, 0, req); end
      @(posedge clk); #1;
      eli = 1'b0; efi = 1'b0;
    end
  endtask

  task automatic drain(string req);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(q_kind.size() == 0, req, "missing expected outputs", q_kind.size(), 0);
    q_kind.delete(); q_data.delete(); q_cyc.delete(); q_req.delete();
  endtask

  initial begin
    #800000;
    if (!done) begin
      check(0, "R10", "watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!vo && !elo && !efo && dout == 0, "R11", "outputs in reset", {vo, elo, efo}, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!vo && !elo && !efo, "R11", "outputs after reset", {vo, elo, efo}, 0);

    frame(1, 4, 3, 0, "R11");  drain("R11");   // no control written yet: dropped
    wr(8, 'h10);
    frame(2, 4, 3, 0, "R8");   drain("R8");    // write waits for this frame end
    frame(3, 4, 3, 1, "R7");   drain("R7");    // full window, markers pass (R4)
    frame(4, 4, 2, 1, "R7");   drain("R7");

    set_win(1, 2, 1, 1);
    frame(5, 5, 4, 1, "R2");   drain("R3");    // interior window
    set_win(0, 0, 0, 0);
    frame(6, 3, 3, 1, "R1");   drain("R1");    // first pixel of first line only
    set_win(2, 2, 2, 2);
    frame(7, 3, 3, 1, "R2");   drain("R2");    // last pixel of last line only
    set_win('h101, 'h102, 0, 'h100);
    frame(8, 260, 2, 1, "R5"); drain("R5");    // high nibble of bounds
    set_win(0, 4095, 0, 4095);

    fork
      frame(9, 4, 2, 1, "R8");
      begin repeat (3) @(posedge clk); wr(8, 2); end
    join
    drain("R8");
    frame(10, 4, 2, 1, "R6");  drain("R6");
    frame(11, 4, 2, 1, "R6");  drain("R6");
    frame(12, 4, 2, 0, "R6");  drain("R6");
    frame(13, 4, 2, 0, "R9");  drain("R9");

    wr(8, 'h1F);
    frame(14, 4, 2, 0, "R9");  drain("R9");
    frame(15, 4, 2, 1, "R5");  drain("R5");    // bit 4 overrides the count
    wr(8, 0);
    frame(16, 4, 2, 1, "R8");  drain("R8");
    frame(17, 4, 2, 0, "R6");  drain("R6");    // N=0
    wr(8, 1);
    frame(18, 4, 2, 0, "R9");  drain("R9");
    frame(19, 3, 2, 1, "R6");  drain("R6");    // N=1
    frame(20, 3, 2, 0, "R6");  drain("R6");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule